// File: doc/BRIEF.md
# Two-Wire Bus Repeater with First-Low Data Arbitration

This block joins two open-drain segments of a two-wire serial bus, one facing the bus master and one facing the slaves. Each wire enters through a synchronizer and leaves as a pull-low enable. Driving that enable low releases the wire; the block never drives a line high. The data wire carries traffic both ways. Its direction for each low pulse goes to whichever segment is first seen low. That segment holds the lock until it goes high again, and the block copies its low onto the other segment.

When the lock is released, a segment still held low by another device takes over at once. The former controlling segment then sees a short hand-over low pulse. A blanking window after every release stops the block's own rising line from being read as a new request. The clock wire is one-way. A direction select chooses which segment is the source, and a low on the destination side is never sent back, so clock stretching is not passed through.

An active-high enable isolates the two segments. A change on the enable or on the clock direction waits until the bus is quiet.

Top module: `twbus_repeater`

## Requirements
- R1: When no lock is held and the bus is enabled, the first data input seen low takes the lock. If both data inputs are seen low in the same cycle, the master side wins.
- R2: While a side holds the lock and its data input is low, the block pulls the other side's data line low. The block never pulls both data lines at once. A low on the locked-out side does not change the direction.
- R3: When the controlling side's data input is seen high, the block stops pulling the other side's data line on the next cycle and gives up the lock.
- R4: If the formerly driven side is still held low by another device once its blanking window ends, that side takes the lock. The block then pulls the former controlling side low until the new controller goes high. After both sides are high, every pull-down is released.
- R5: For BLANK_CYCLES cycles after the block releases a data line, a low on that line's input cannot take the lock. A line that rises within that window causes no hand-over.
- R6: With the effective clock direction at 0, a low on the master-side clock input makes the block pull the slave-side clock line low one cycle after the synchronized sample. With it at 1, a low on the slave-side clock input makes the block pull the master-side clock line low.
- R7: The block never pulls the clock line of the side that is currently the clock source. A low held on the destination clock line is never copied back.
- R8: While the effective enable is 0, all four pull-down outputs are 0.
- R9: New values on the enable input and the clock direction input are taken only in a cycle where all four synchronized wire inputs are high and no data lock is held. Until then the previous values stay in force.
- R10: Reset clears the data lock, sets every pull-down output to 0, and sets the effective enable to 0. The enable takes effect at the first quiet-bus cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Connects the segments when 1, isolates them when 0 |
| scl_dir_i | input | 1 | Clock source select: 0 master side, 1 slave side |
| m_sda_i | input | 1 | Master-side data wire level |
| s_sda_i | input | 1 | Slave-side data wire level |
| m_scl_i | input | 1 | Master-side clock wire level |
| s_scl_i | input | 1 | Slave-side clock wire level |
| m_sda_pull_o | output | 1 | Pull master-side data wire low |
| s_sda_pull_o | output | 1 | Pull slave-side data wire low |
| m_scl_pull_o | output | 1 | Pull master-side clock wire low |
| s_scl_pull_o | output | 1 | Pull slave-side clock wire low |

## Verification
The assertions assume that each wire input is the wired-AND of the block's own pull-down and the external devices on that segment. Under that assumption a data line the block holds low reads low, and a quiet bus reads all ones. The bench builds each segment that way. It can also delay the rise of the slave data line by a set number of cycles after the block lets go, to imitate a heavily loaded segment. The enable and the clock direction are changed both on a quiet bus and in the middle of a transfer, so the assertions see the deferral that R9 describes.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [1:0] {
    LOCK_NONE = 2'd0,
    LOCK_MST  = 2'd1,
    LOCK_SLV  = 2'd2
  } lock_e;

  localparam int SIDE_MST = 0;
  localparam int SIDE_SLV = 1;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/twr_blank.sv
module twr_blank #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic line_low,
  output logic low_seen
);
  generate
    if (CYCLES == 0) begin : g_none
      assign low_seen = line_low;
    end else begin : g_cnt
      localparam int CW = $clog2(CYCLES + 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= CW'(CYCLES);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
      end

      assign low_seen = line_low && (cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/twr_data_lock.sv
module twr_data_lock
  import twr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  enable,
  input  logic  m_low,
  input  logic  s_low,
  input  logic  m_high,
  input  logic  s_high,
  output lock_e lock_q,
  output logic  m_pull_q,
  output logic  s_pull_q,
  output logic  m_release,
  output logic  s_release
);
  lock_e lock_n;

  always_comb begin
    lock_n = lock_q;
    if (!enable) begin
      lock_n = LOCK_NONE;
    end else begin
      case (lock_q)
        LOCK_NONE: begin
          if (m_low)      lock_n = LOCK_MST;
          else if (s_low) lock_n = LOCK_SLV;
        end
        LOCK_MST: if (m_high) lock_n = LOCK_NONE;
        LOCK_SLV: if (s_high) lock_n = LOCK_NONE;
        default:  lock_n = LOCK_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= LOCK_NONE;
      m_pull_q <= 1'b0;
      s_pull_q <= 1'b0;
    end else begin
      lock_q   <= lock_n;
      m_pull_q <= (lock_n == LOCK_SLV);
      s_pull_q <= (lock_n == LOCK_MST);
    end
  end

  assign m_release = m_pull_q && (lock_n != LOCK_SLV);
  assign s_release = s_pull_q && (lock_n != LOCK_MST);
endmodule

// File: rtl/twbus_repeater.sv
module twbus_repeater
  import twr_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic scl_dir_i,
  input  logic m_sda_i,
  input  logic s_sda_i,
  input  logic m_scl_i,
  input  logic s_scl_i,
  output logic m_sda_pull_o,
  output logic s_sda_pull_o,
  output logic m_scl_pull_o,
  output logic s_scl_pull_o
);
  localparam int WIRES = 4;

  logic [WIRES-1:0] wire_s;
  logic [1:0]       ctl_s;
  logic m_sda_s, s_sda_s, m_scl_s, s_scl_s;
  logic en_eff, dir_eff;
  logic bus_quiet;
  lock_e lock_q;

  logic [NUM_SIDES-1:0] side_raw_low, side_low, side_release;
  logic m_scl_pull_q, s_scl_pull_q;

  twr_sync #(.W(WIRES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_wsync (
    .clk(clk), .rst(rst),
    .d({s_scl_i, m_scl_i, s_sda_i, m_sda_i}),
    .q(wire_s)
  );

  twr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_csync (
    .clk(clk), .rst(rst),
    .d({scl_dir_i, enable_i}),
    .q(ctl_s)
  );

  assign m_sda_s = wire_s[0];
  assign s_sda_s = wire_s[1];
  assign m_scl_s = wire_s[2];
  assign s_scl_s = wire_s[3];

  assign bus_quiet = (&wire_s) && (lock_q == LOCK_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_eff  <= 1'b0;
      dir_eff <= 1'b0;
    end else if (bus_quiet) begin
      en_eff  <= ctl_s[0];
      dir_eff <= ctl_s[1];
    end
  end

  assign side_raw_low[SIDE_MST] = !m_sda_s;
  assign side_raw_low[SIDE_SLV] = !s_sda_s;

  generate
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
      twr_blank #(.CYCLES(BLANK_CYCLES)) u_blank (
        .clk(clk), .rst(rst),
        .load(side_release[g]),
        .line_low(side_raw_low[g]),
        .low_seen(side_low[g])
      );
    end
  endgenerate

  twr_data_lock u_lock (
    .clk(clk), .rst(rst),
    .enable(en_eff),
    .m_low(side_low[SIDE_MST]),
    .s_low(side_low[SIDE_SLV]),
    .m_high(m_sda_s),
    .s_high(s_sda_s),
    .lock_q(lock_q),
    .m_pull_q(m_sda_pull_o),
    .s_pull_q(s_sda_pull_o),
    .m_release(side_release[SIDE_MST]),
    .s_release(side_release[SIDE_SLV])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_scl_pull_q <= 1'b0;
      s_scl_pull_q <= 1'b0;
    end else begin
      m_scl_pull_q <= en_eff &&  dir_eff && !s_scl_s;
      s_scl_pull_q <= en_eff && !dir_eff && !m_scl_s;
    end
  end

  assign m_scl_pull_o = m_scl_pull_q;
  assign s_scl_pull_o = s_scl_pull_q;
endmodule

// File: rtl/twr_checker.sv
module twr_checker (
  input logic clk,
  input logic rst,
  input logic en_eff,
  input logic dir_eff,
  input logic m_sda_s,
  input logic s_sda_s,
  input logic m_scl_s,
  input logic s_scl_s,
  input logic m_sda_pull_o,
  input logic s_sda_pull_o,
  input logic m_scl_pull_o,
  input logic s_scl_pull_o
);
  AST_DATA_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(m_sda_pull_o && s_sda_pull_o)); // R2

  AST_HOLD_MST_LOW: assert property (@(posedge clk) disable iff (rst)
    s_sda_pull_o && !m_sda_s |=> s_sda_pull_o); // R2

  AST_HOLD_SLV_LOW: assert property (@(posedge clk) disable iff (rst)
    m_sda_pull_o && !s_sda_s |=> m_sda_pull_o); // R2

  AST_REL_MST_HIGH: assert property (@(posedge clk) disable iff (rst)
    s_sda_pull_o && m_sda_s |=> !s_sda_pull_o); // R3

  AST_REL_SLV_HIGH: assert property (@(posedge clk) disable iff (rst)
    m_sda_pull_o && s_sda_s |=> !m_sda_pull_o); // R3

  AST_SCL_COPY_FWD: assert property (@(posedge clk) disable iff (rst)
    en_eff && !dir_eff && !m_scl_s |=> s_scl_pull_o); // R6

  AST_SCL_COPY_REV: assert property (@(posedge clk) disable iff (rst)
    en_eff && dir_eff && !s_scl_s |=> m_scl_pull_o); // R6

  AST_SCL_NO_BACK_FWD: assert property (@(posedge clk) disable iff (rst)
    !dir_eff |-> !m_scl_pull_o); // R7

  AST_SCL_NO_BACK_REV: assert property (@(posedge clk) disable iff (rst)
    dir_eff |-> !s_scl_pull_o); // R7

  AST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    !en_eff |-> !(m_sda_pull_o || s_sda_pull_o || m_scl_pull_o || s_scl_pull_o)); // R8

  AST_CFG_ON_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en_eff != $past(en_eff)) || (dir_eff != $past(dir_eff))
      |-> $past(m_sda_s && s_sda_s && m_scl_s && s_scl_s)); // R9
endmodule

bind twbus_repeater twr_checker u_chk (
  .clk(clk), .rst(rst),
  .en_eff(en_eff), .dir_eff(dir_eff),
  .m_sda_s(m_sda_s), .s_sda_s(s_sda_s),
  .m_scl_s(m_scl_s), .s_scl_s(s_scl_s),
  .m_sda_pull_o(m_sda_pull_o), .s_sda_pull_o(s_sda_pull_o),
  .m_scl_pull_o(m_scl_pull_o), .s_scl_pull_o(s_scl_pull_o)
);

// File: tb/test_twbus_repeater.sv
`timescale 1ns/1ps
module test_twbus_repeater;
  localparam int B = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_i = 1'b0, scl_dir_i = 1'b0;
  logic m_dev_sda = 1'b1, s_dev_sda = 1'b1, m_dev_scl = 1'b1, s_dev_scl = 1'b1;
  logic m_sda_pull_o, s_sda_pull_o, m_scl_pull_o, s_scl_pull_o;
  int   s_rise_cfg = 0;
  int   s_rise_cnt = 0;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  wire m_sda = m_dev_sda & ~m_sda_pull_o;
  wire s_sda = s_dev_sda & ~s_sda_pull_o & (s_rise_cnt == 0);
  wire m_scl = m_dev_scl & ~m_scl_pull_o;
  wire s_scl = s_dev_scl & ~s_scl_pull_o;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (s_sda_pull_o)        s_rise_cnt <= s_rise_cfg;
    else if (s_rise_cnt != 0) s_rise_cnt <= s_rise_cnt - 1;
  end

  twbus_repeater #(.SYNC_STAGES(2), .BLANK_CYCLES(B)) i_twbus_repeater (
    .clk(clk), .rst(rst), .enable_i(enable_i), .scl_dir_i(scl_dir_i),
    .m_sda_i(m_sda), .s_sda_i(s_sda), .m_scl_i(m_scl), .s_scl_i(s_scl),
    .m_sda_pull_o(m_sda_pull_o), .s_sda_pull_o(s_sda_pull_o),
    .m_scl_pull_o(m_scl_pull_o), .s_scl_pull_o(s_scl_pull_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pulls();
    return {m_sda_pull_o, s_sda_pull_o, m_scl_pull_o, s_scl_pull_o};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(5);
    chk("R10 reset pulls", pulls(), 4'b0000);
    rst = 1'b0;
    enable_i = 1'b1;
    cyc(10);
    chk("R10 enabled idle", pulls(), 4'b0000);

    // master takes data lock, slave low ignored, release
    m_dev_sda = 1'b0; cyc(6);
    chk("R1 master first", pulls(), 4'b0100);
    s_dev_sda = 1'b0; cyc(6);
    chk("R2 lockout", pulls(), 4'b0100);
    s_dev_sda = 1'b1; cyc(2);
    m_dev_sda = 1'b1; cyc(10);
    chk("R3 master release", pulls(), 4'b0000);

    // slave first
    s_dev_sda = 1'b0; cyc(6);
    chk("R1 slave first", pulls(), 4'b1000);
    s_dev_sda = 1'b1; cyc(10);
    chk("R3 slave release", pulls(), 4'b0000);

    // tie then hand-over
    m_dev_sda = 1'b0; s_dev_sda = 1'b0; cyc(6);
    chk("R1 tie master wins", pulls(), 4'b0100);
    m_dev_sda = 1'b1; cyc(B + 10);
    chk("R4 hand-over", pulls(), 4'b1000);
    s_dev_sda = 1'b1; cyc(B + 10);
    chk("R4 settled", pulls(), 4'b0000);

    // slow-rise sweep on slave data segment
    for (int r = 0; r <= 10; r++) begin
      bit seen = 1'b0;
      s_rise_cfg = r;
      m_dev_sda = 1'b0; cyc(6);
      m_dev_sda = 1'b1;
      for (int k = 0; k < 40; k++) begin
        cyc(1);
        if (m_sda_pull_o) seen = 1'b1;
      end
      if (r <= B - 3) chk($sformatf("R5 blank rise=%0d", r), {3'b0, seen}, 4'b0000);
      if (r >= B + 3) chk($sformatf("R4 reversal rise=%0d", r), {3'b0, seen}, 4'b0001);
      chk($sformatf("R4 no lockup rise=%0d", r), pulls(), 4'b0000);
    end
    s_rise_cfg = 0;

    // clock forward sweep
    for (int t = 0; t < 6; t++) begin
      m_dev_scl = t[0]; cyc(5);
      chk($sformatf("R6 fwd step %0d", t), pulls(), {3'b000, ~m_dev_scl});
    end
    m_dev_scl = 1'b1; cyc(5);
    s_dev_scl = 1'b0; cyc(6);
    chk("R7 no fwd feedback", pulls(), 4'b0000);
    s_dev_scl = 1'b1; cyc(4);

    // reverse direction
    scl_dir_i = 1'b1; cyc(8);
    s_dev_scl = 1'b0; cyc(5);
    chk("R6 reverse copy", pulls(), 4'b0010);
    m_dev_scl = 1'b0; cyc(5);
    chk("R7 no rev feedback", pulls(), 4'b0010);
    m_dev_scl = 1'b1; s_dev_scl = 1'b1; cyc(6);
    chk("R6 reverse release", pulls(), 4'b0000);

    // direction change deferred while clock busy
    scl_dir_i = 1'b0; cyc(8);
    m_dev_scl = 1'b0; cyc(5);
    scl_dir_i = 1'b1; cyc(8);
    chk("R9 dir deferred", pulls(), 4'b0001);
    m_dev_scl = 1'b1; cyc(8);
    s_dev_scl = 1'b0; cyc(5);
    chk("R9 dir applied", pulls(), 4'b0010);
    s_dev_scl = 1'b1; cyc(6);
    scl_dir_i = 1'b0; cyc(8);

    // enable deferred mid-transfer, then isolation
    m_dev_sda = 1'b0; cyc(6);
    enable_i = 1'b0; cyc(8);
    chk("R9 enable deferred", pulls(), 4'b0100);
    m_dev_sda = 1'b1; cyc(10);
    m_dev_sda = 1'b0; m_dev_scl = 1'b0; cyc(8);
    chk("R8 isolated master low", pulls(), 4'b0000);
    m_dev_sda = 1'b1; m_dev_scl = 1'b1; cyc(4);
    s_dev_sda = 1'b0; cyc(8);
    chk("R8 isolated slave low", pulls(), 4'b0000);
    s_dev_sda = 1'b1; cyc(4);
    enable_i = 1'b1; cyc(10);
    m_dev_sda = 1'b0; cyc(6);
    chk("R9 enable applied", pulls(), 4'b0100);
    m_dev_sda = 1'b1; cyc(10);

    finish_run();
  end
endmodule